// File: doc/BRIEF.md
# Masked Interrupt Status Register Bank

This block collects interrupt events from neighbouring logic into a status register. It drives one level-sensitive interrupt line that stays high while any status bit is set and the mask does not block it. Software reaches the block through a plain register port with a word address, a write enable, write data and combinational read data.

The mask cannot be written directly. Software clears mask bits by writing ones to an unmask strobe register and sets them by writing ones to a mask strobe register. A third strobe register, the force register, lets software raise status bits itself. All three strobes always read back as zero.

Status bits are cleared by writing ones to them. A hardware event on the same bit in the same cycle takes priority over that clear. A parameter picks which bit positions are implemented, which of those are write-one-to-clear and which are reserved.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset the status register (offset 0) reads 0x00000000, the mask register (offset 1) reads 0x0003BFFF and `irq` is low.
- R2: In every cycle after reset, `irq` is high exactly when some status bit is set whose mask bit is clear. A register write changes `irq` in the cycle after the write edge.
- R3: Writing the unmask strobe (offset 2) clears every mask bit where the written data has a one, and leaves all other mask bits unchanged. Offset 2 always reads zero.
- R4: Writing the mask strobe (offset 3) sets every non-reserved mask bit where the written data has a one. Offset 3 always reads zero.
- R5: Writing the force strobe (offset 4) ORs the non-reserved bits of the written data into status. Offset 4 always reads zero.
- R6: A status write clears status bits in the set 0x0003BFFF where the data has a one and leaves the other bits of that set alone. Bits in 0x003C0000 take the written value directly.
- R7: Bits in 0xFFC04000 read as zero in status and in mask. Writes, strobes and hardware events never set them.
- R8: A direct write to the mask register (offset 1) leaves the mask unchanged.
- R9: A one on `src_set[i]` for one cycle sets non-reserved status bit i at that edge. When a status write clears the same bit in the same cycle, the bit still ends up set.
- R10: Offsets 5 and above read zero, and writes to them change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | ADDR_W (4) | Word offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| src_set | input | DATA_W (32) | One-cycle set pulses from event sources |
| irq | output | 1 | Level interrupt: unmasked status pending |

## Verification
A walking one is passed across all 32 bit positions. Each step unmasks the bit, forces it, clears it through the status register and then masks it again. This separates the write-one-to-clear bits, the directly written bits and the reserved bits, and it catches a wrong bit in a parameter mask or a polarity swap on the strobes. Wide all-ones patterns are also written to the mask register, to the unmapped offsets and to the force strobe. They show that a stray write path would corrupt state, and that reserved bits stay zero. A cycle in which a hardware event and a status clear hit the same bits shows which of the two takes priority.

// File: rtl/irq_mask_bank_pkg.sv
package irq_mask_bank_pkg;
   typedef enum logic [2:0] {
      OFS_STATUS  = 3'd0,
      OFS_MASK    = 3'd1,
      OFS_UNMASK  = 3'd2,
      OFS_MASKSET = 3'd3,
      OFS_FORCE   = 3'd4
   } reg_ofs_e;

   localparam int unsigned OFS_W = 3;
endpackage

// File: rtl/irq_mask_bank_decode.sv
module irq_mask_bank_decode
   import irq_mask_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_status,
   output logic              wr_unmask,
   output logic              wr_maskset,
   output logic              wr_force,
   output logic              sel_status,
   output logic              sel_mask
);
   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_ofs_e o);
      return a == ADDR_W'(o);
   endfunction

   always_comb begin
      sel_status = hit(addr, OFS_STATUS);
      sel_mask   = hit(addr, OFS_MASK);
      wr_status  = wr_en && sel_status;
      wr_unmask  = wr_en && hit(addr, OFS_UNMASK);
      wr_maskset = wr_en && hit(addr, OFS_MASKSET);
      wr_force   = wr_en && hit(addr, OFS_FORCE);
   end
endmodule

// File: rtl/irq_mask_bank_status.sv
module irq_mask_bank_status #(
   parameter int unsigned DATA_W   = 32,
   parameter logic [DATA_W-1:0] W1C_BITS  = DATA_W'(32'h0003BFFF),
   parameter logic [DATA_W-1:0] RSVD_BITS = DATA_W'(32'hFFC04000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_status,
   input  logic              wr_force,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] src_set,
   output logic [DATA_W-1:0] status_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (RSVD_BITS[i]) begin : g_rsvd
         assign status_q[i] = 1'b0;
      end else if (W1C_BITS[i]) begin : g_w1c
         logic bit_q;
         logic set_ev;
         assign set_ev = src_set[i] | (wr_force & wdata[i]);
         always_ff @(posedge clk) begin
            if (!rst_n)                        bit_q <= 1'b0;
            else if (set_ev)                   bit_q <= 1'b1;
            else if (wr_status && wdata[i])    bit_q <= 1'b0;
         end
         assign status_q[i] = bit_q;
      end else begin : g_rw
         logic bit_q;
         logic set_ev;
         assign set_ev = src_set[i] | (wr_force & wdata[i]);
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_ev)     bit_q <= 1'b1;
            else if (wr_status)  bit_q <= wdata[i];
         end
         assign status_q[i] = bit_q;
      end
   end
endmodule

// File: rtl/irq_mask_bank_mask.sv
module irq_mask_bank_mask #(
   parameter int unsigned DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_BITS = DATA_W'(32'h0003BFFF),
   parameter logic [DATA_W-1:0] RSVD_BITS  = DATA_W'(32'hFFC04000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_unmask,
   input  logic              wr_maskset,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (RSVD_BITS[i]) begin : g_rsvd
         assign mask_q[i] = 1'b0;
      end else begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                      bit_q <= RESET_BITS[i];
            else if (wr_unmask && wdata[i])  bit_q <= 1'b0;
            else if (wr_maskset && wdata[i]) bit_q <= 1'b1;
         end
         assign mask_q[i] = bit_q;
      end
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter logic [DATA_W-1:0] W1C_BITS   = DATA_W'(32'h0003BFFF),
   parameter logic [DATA_W-1:0] RSVD_BITS  = DATA_W'(32'hFFC04000),
   parameter logic [DATA_W-1:0] MASK_RESET = DATA_W'(32'h0003BFFF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] src_set,
   output logic              irq
);
   localparam logic [DATA_W-1:0] LIVE_BITS = ~RSVD_BITS;

   if (ADDR_W < irq_mask_bank_pkg::OFS_W) begin : g_chk_addr
      $error("irq_mask_bank: ADDR_W too small for the register map");
   end
   if ((W1C_BITS & RSVD_BITS) != '0) begin : g_chk_w1c
      $error("irq_mask_bank: W1C_BITS overlaps RSVD_BITS");
   end
   if ((MASK_RESET & RSVD_BITS) != '0) begin : g_chk_rst
      $error("irq_mask_bank: MASK_RESET overlaps RSVD_BITS");
   end

   logic wr_status, wr_unmask, wr_maskset, wr_force;
   logic sel_status, sel_mask;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] pending;

   irq_mask_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_status  (wr_status),
      .wr_unmask  (wr_unmask),
      .wr_maskset (wr_maskset),
      .wr_force   (wr_force),
      .sel_status (sel_status),
      .sel_mask   (sel_mask)
   );

   irq_mask_bank_status #(
      .DATA_W    (DATA_W),
      .W1C_BITS  (W1C_BITS),
      .RSVD_BITS (RSVD_BITS)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_status (wr_status),
      .wr_force  (wr_force),
      .wdata     (wdata),
      .src_set   (src_set),
      .status_q  (status_q)
   );

   irq_mask_bank_mask #(
      .DATA_W     (DATA_W),
      .RESET_BITS (MASK_RESET),
      .RSVD_BITS  (RSVD_BITS)
   ) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_unmask  (wr_unmask),
      .wr_maskset (wr_maskset),
      .wdata      (wdata),
      .mask_q     (mask_q)
   );

   always_comb begin
      pending = status_q & ~mask_q & LIVE_BITS;
      irq     = |pending;
      if (sel_status)    rdata = status_q;
      else if (sel_mask) rdata = mask_q;
      else               rdata = '0;
   end
endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter logic [DATA_W-1:0] RSVD_BITS = DATA_W'(32'hFFC04000)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] src_set,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] mask_q
);
   localparam logic [DATA_W-1:0] LIVE = ~RSVD_BITS;

   AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(2)) |=> ((mask_q & $past(wdata)) == '0)); // R3

   AST_MASKSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(3)) |=> ((mask_q & $past(wdata) & LIVE) == ($past(wdata) & LIVE))); // R4

   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4)) |=> ((status_q & $past(wdata) & LIVE) == ($past(wdata) & LIVE))); // R5

   AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= ADDR_W'(2)) |-> (rdata == '0)); // R10

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q | mask_q) & RSVD_BITS) == '0); // R7

   AST_MASK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(1)) |=> $stable(mask_q)); // R8

   AST_SRC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_set & LIVE) != '0) |=> ((status_q & $past(src_set) & LIVE) == ($past(src_set) & LIVE))); // R9
endmodule

bind irq_mask_bank irq_mask_bank_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .RSVD_BITS (RSVD_BITS)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .src_set  (src_set),
   .status_q (status_q),
   .mask_q   (mask_q)
);

// File: tb/irq_mask_bank_tb_top.sv
`timescale 1ns/1ps
module irq_mask_bank_tb_top;
   localparam logic [31:0] RSVD  = 32'hFFC04000;
   localparam logic [31:0] LIVE  = ~RSVD;
   localparam logic [31:0] W1C   = 32'h0003BFFF;
   localparam logic [31:0] PLAIN = 32'h003C0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] src_set = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_stat;
   logic [31:0] m_mask;

   always #2.5 clk = ~clk;

   irq_mask_bank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .src_set(src_set), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   // one clock cycle with optional write and event pulse; model updated from requirements
   task automatic cyc(input logic we, input logic [3:0] a,
                      input logic [31:0] d, input logic [31:0] s);
      @(negedge clk);
      wr_en = we; addr = a; wdata = d; src_set = s;
      @(negedge clk);
      wr_en = 1'b0; src_set = '0;
      if (we) begin
         case (a)
            4'd0: m_stat = (m_stat & ~(d & W1C) & ~PLAIN) | (d & PLAIN);
            4'd2: m_mask = m_mask & ~d;
            4'd3: m_mask = m_mask | (d & LIVE);
            4'd4: m_stat = m_stat | (d & LIVE);
            default: ;
         endcase
      end
      m_stat = m_stat | (s & LIVE);
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic check_state(input string req);
      logic [31:0] v;
      rd(4'd0, v); check(req, "status", v, m_stat);
      rd(4'd1, v); check(req, "mask", v, m_mask);
      check(req, "irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      m_stat = '0;
      m_mask = W1C;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      rd(4'd0, v); check("R1", "status reset", v, 32'h0);
      rd(4'd1, v); check("R1", "mask reset", v, 32'h0003BFFF);
      check("R1", "irq reset", {31'd0, irq}, 32'd0);

      // walking one over every bit position: R2 R3 R4 R5 R6 R7
      for (int b = 0; b < 32; b++) begin
         logic [31:0] bit1;
         bit1 = 32'h1 << b;
         cyc(1'b1, 4'd2, bit1, '0);  check_state("R3");
         cyc(1'b1, 4'd4, bit1, '0);  check_state("R5");
         if (LIVE[b]) check("R2", "irq after force", {31'd0, irq}, 32'd1);
         else         check("R7", "reserved bit", {31'd0, irq}, 32'd0);
         cyc(1'b1, 4'd0, bit1, '0);  check_state("R6");
         cyc(1'b1, 4'd0, 32'h0, '0); check_state("R6");
         cyc(1'b1, 4'd3, bit1, '0);  check_state("R4");
      end

      // strobe registers read zero after being written
      cyc(1'b1, 4'd2, 32'hFFFFFFFF, '0);
      rd(4'd2, v); check("R3", "unmask readback", v, 32'h0);
      check_state("R3");
      cyc(1'b1, 4'd3, 32'hFFFFFFFF, '0);
      rd(4'd3, v); check("R4", "maskset readback", v, 32'h0);
      check_state("R4");
      cyc(1'b1, 4'd4, 32'hFFFFFFFF, '0);
      rd(4'd4, v); check("R5", "force readback", v, 32'h0);
      check("R7", "status reserved", m_stat & RSVD, 32'h0);
      check_state("R7");

      // R8: direct mask writes ignored
      cyc(1'b1, 4'd1, 32'h0, '0);
      check_state("R8");
      cyc(1'b1, 4'd2, 32'h00000F0F, '0);
      cyc(1'b1, 4'd1, 32'hFFFFFFFF, '0);
      check_state("R8");

      // R10: unmapped offsets
      for (int a = 5; a < 16; a++) begin
         cyc(1'b1, 4'(a), 32'hFFFFFFFF, '0);
         rd(4'(a), v); check("R10", "unmapped read", v, 32'h0);
         check_state("R10");
      end

      // R9: event pulse alone, then against a same-cycle clear
      cyc(1'b1, 4'd0, 32'hFFFFFFFF, '0);
      cyc(1'b1, 4'd0, 32'h0, '0);
      check_state("R6");
      cyc(1'b0, 4'd0, 32'h0, 32'h00000005);
      check_state("R9");
      cyc(1'b1, 4'd0, 32'h00000005, 32'h00000004);
      check("R9", "set wins", m_stat & 32'h5, 32'h4);
      check_state("R9");
      cyc(1'b0, 4'd0, 32'h0, 32'hFFFFFFFF);
      check_state("R7");

      // R2: irq drops when every pending bit is masked
      cyc(1'b1, 4'd3, 32'hFFFFFFFF, '0);
      check("R2", "irq masked", {31'd0, irq}, 32'd0);
      cyc(1'b1, 4'd2, 32'h00020000, '0);
      check("R2", "irq unmasked", {31'd0, irq}, 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule